// File: doc/BRIEF.md
# Indirect and External Data-Move Unit

This unit carries out one family of byte-oriented data-transfer instructions for a small 8-bit controller core. It covers the following operations:

- immediate stores to a direct internal-RAM address;
- stores through the register-indirect pointers R0 and R1;
- loading of the 16-bit data pointer;
- table lookups in code memory, offset by the accumulator;
- reads and writes of external data memory.

The unit owns the accumulator, the data pointer and the program counter. It talks to three memories, each with a synchronous port whose read data arrives one clock after the address.

A fetch stage presents the opcode and up to two operand bytes with a one-clock `start` strobe while the unit is idle. The unit latches them and stays `busy` for exactly the cycle count of that opcode. It raises `done` in the final cycle, and all results commit on the clock edge that ends that cycle.

In the acceptance cycle the unit already reads the pointer register of the selected bank. This is what lets an indirect store finish in a single cycle. Opcodes outside the family raise `illegal` alongside `done` after one cycle and leave every register untouched.

Top module: `dmove_unit`

## Requirements
- R1: After synchronous reset, `acc`, `dptr` and `pc` read zero, and `busy` and `done` are low.
- R2: Each opcode keeps `busy` high for exactly its cycle count and raises `done` only in the last of those cycles. The cycle counts are:
  - 3 cycles: 0x75, 0x90, 0x83, 0x93;
  - 2 cycles: 0xA6/A7, 0x76/77, 0xE0, 0xE2/E3, 0xF0, 0xF2/F3;
  - 1 cycle: 0xF6/F7.

  When the opcode completes, `pc` advances by the instruction's byte length. The lengths are:
  - 3 bytes: 0x75, 0x90;
  - 2 bytes: 0xA6/A7, 0x76/77;
  - 1 byte: all others.
- R3: Opcode 0x75 writes operand byte 2 to the internal-RAM address given by operand byte 1.
- R4: Opcodes 0xF6/0xF7 write `acc` to the internal-RAM address held in pointer register Ri. Bit 0 of the opcode selects i. Ri lives at internal address bank*8+i, where bank is `bank_sel`.
- R5: Opcodes 0xA6/0xA7 copy the internal byte at the address in operand 1 to the address held in Ri. Opcodes 0x76/0x77 write operand 1 to the address held in Ri.
- R6: Opcode 0x90 sets the high byte of `dptr` from operand 1 one cycle before it sets the low byte from operand 2. In the final cycle, the high byte is already new and the low byte is still old.
- R7: Opcode 0x93 loads `acc` from code memory at `acc`+`dptr`. Opcode 0x83 loads `acc` from code memory at `acc`+`pc`+1. Both sums wrap modulo 65536.
- R8: Opcodes 0xE2/0xE3 load `acc` from external address {0x00, Ri}. Opcode 0xE0 loads `acc` from external address `dptr`.
- R9: Opcodes 0xF2/0xF3 write `acc` to external address {0x00, Ri}. Opcode 0xF0 writes `acc` to external address `dptr`.
- R10: Any other opcode completes in one cycle with `illegal` high together with `done`. It changes neither `acc`, `dptr` nor `pc`, and it writes no memory.
- R11: At most one of `iram_we`, `code_re`, `xd_re` and `xd_we` is high in any cycle, and only while `busy`. Memory writes occur only in the final cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction present; accepted when idle |
| opcode | input | 8 | Instruction opcode |
| operand1 | input | 8 | First operand byte |
| operand2 | input | 8 | Second operand byte |
| bank_sel | input | 2 | Active register bank |
| iram_addr | output | 8 | Internal RAM address (read every cycle) |
| iram_we | output | 1 | Internal RAM write enable |
| iram_wdata | output | 8 | Internal RAM write data |
| iram_rdata | input | 8 | Internal RAM read data, one cycle after address |
| code_addr | output | 16 | Code memory address |
| code_re | output | 1 | Code memory read strobe |
| code_rdata | input | 8 | Code memory data, one cycle after strobe |
| xd_addr | output | 16 | External data address |
| xd_re | output | 1 | External data read strobe |
| xd_we | output | 1 | External data write strobe |
| xd_wdata | output | 8 | External data write data |
| xd_rdata | input | 8 | External data read data, one cycle after strobe |
| acc | output | 8 | Accumulator |
| dptr | output | 16 | Data pointer |
| pc | output | 16 | Program counter |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final cycle of the instruction |
| illegal | output | 1 | Completed instruction was not recognised |

## Verification
Several rules are checked by assertions on every clock:
- the strobe exclusivity and the confinement of writes to the final cycle;
- `done` only while `busy`, with the counter staying below the latched cycle count;
- `illegal` implying `done`, with register state held across an unrecognised opcode;
- the data pointer's high byte being in place by the final cycle of a load.

Only the directed scenarios can show that the data is correct. That covers the right bytes reaching the right addresses, bank-relative pointer lookup, the accumulator offset and its 16-bit wrap in table lookups, the program-counter base of the PC-relative form, and the exact busy length and byte length of each opcode.

// File: rtl/dmu_pkg.sv
package dmu_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 2;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [3:0] {
        K_DIR_IMM,
        K_IND_ACC,
        K_IND_DIR,
        K_IND_IMM,
        K_LD_DPTR,
        K_CODE_DP,
        K_CODE_PC,
        K_XRD_RI,
        K_XRD_DP,
        K_XWR_RI,
        K_XWR_DP,
        K_BAD
    } op_kind_e;

    typedef struct packed {
        op_kind_e         kind;
        logic [CNT_W-1:0] ncyc;
        logic [1:0]       nbytes;
    } dec_t;

    function automatic dec_t decode_op(input byte_t op);
        dec_t d;
        d = '{kind: K_BAD, ncyc: 2'd1, nbytes: 2'd0};
        casez (op)
            8'h75:        d = '{kind: K_DIR_IMM, ncyc: 2'd3, nbytes: 2'd3};
            8'b1111_011?: d = '{kind: K_IND_ACC, ncyc: 2'd1, nbytes: 2'd1};
            8'b1010_011?: d = '{kind: K_IND_DIR, ncyc: 2'd2, nbytes: 2'd2};
            8'b0111_011?: d = '{kind: K_IND_IMM, ncyc: 2'd2, nbytes: 2'd2};
            8'h90:        d = '{kind: K_LD_DPTR, ncyc: 2'd3, nbytes: 2'd3};
            8'h93:        d = '{kind: K_CODE_DP, ncyc: 2'd3, nbytes: 2'd1};
            8'h83:        d = '{kind: K_CODE_PC, ncyc: 2'd3, nbytes: 2'd1};
            8'b1110_001?: d = '{kind: K_XRD_RI,  ncyc: 2'd2, nbytes: 2'd1};
            8'hE0:        d = '{kind: K_XRD_DP,  ncyc: 2'd2, nbytes: 2'd1};
            8'b1111_001?: d = '{kind: K_XWR_RI,  ncyc: 2'd2, nbytes: 2'd1};
            8'hF0:        d = '{kind: K_XWR_DP,  ncyc: 2'd2, nbytes: 2'd1};
            default:      d = '{kind: K_BAD,     ncyc: 2'd1, nbytes: 2'd0};
        endcase
        return d;
    endfunction

    // pointer register i of a bank sits at bank*8 + i
    function automatic byte_t ptr_reg_addr(input logic [1:0] bank, input logic sel);
        return {3'b000, bank, 2'b00, sel};
    endfunction
endpackage

// File: rtl/dmu_decoder.sv
module dmu_decoder
    import dmu_pkg::*;
(
    input  byte_t op,
    output dec_t  dec
);
    always_comb dec = decode_op(op);
endmodule

// File: rtl/dmu_seq.sv
module dmu_seq
    import dmu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] ncyc,
    output logic             busy,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            busy <= start;
            cnt  <= '0;
        end else if (last) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = busy && (cnt == ncyc - 1'b1);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt < ncyc));
endmodule

// File: rtl/dmu_arch_regs.sv
module dmu_arch_regs
    import dmu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       acc_we,
    input  byte_t      acc_d,
    input  logic       dph_we,
    input  logic       dpl_we,
    input  byte_t      dp_d,
    input  logic       pc_adv,
    input  logic [1:0] pc_step,
    output byte_t      acc,
    output addr_t      dptr,
    output addr_t      pc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            dptr <= '0;
            pc   <= '0;
        end else begin
            if (acc_we) acc <= acc_d;
            if (dph_we) dptr[ADDR_W-1:DATA_W] <= dp_d;
            if (dpl_we) dptr[DATA_W-1:0] <= dp_d;
            if (pc_adv) pc <= pc + addr_t'(pc_step);
        end
    end

    // R6
    dp_split_chk: assert property (@(posedge clk) disable iff (rst)
        !(dph_we && dpl_we));
endmodule

// File: rtl/dmove_unit.sv
module dmove_unit
    import dmu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [7:0]  opcode,
    input  logic [7:0]  operand1,
    input  logic [7:0]  operand2,
    input  logic [1:0]  bank_sel,
    output logic [7:0]  iram_addr,
    output logic        iram_we,
    output logic [7:0]  iram_wdata,
    input  logic [7:0]  iram_rdata,
    output logic [15:0] code_addr,
    output logic        code_re,
    input  logic [7:0]  code_rdata,
    output logic [15:0] xd_addr,
    output logic        xd_re,
    output logic        xd_we,
    output logic [7:0]  xd_wdata,
    input  logic [7:0]  xd_rdata,
    output logic [7:0]  acc,
    output logic [15:0] dptr,
    output logic [15:0] pc,
    output logic        busy,
    output logic        done,
    output logic        illegal
);
    dec_t             dec_in, dec_q;
    byte_t            b1_q, b2_q, ptr_q, ptr_now;
    logic [CNT_W-1:0] cnt;
    logic             last, accept;
    logic             acc_we, dph_we, dpl_we, pc_adv;
    byte_t            acc_d, dp_d;

    dmu_decoder u_dec (.op(opcode), .dec(dec_in));

    dmu_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .ncyc(dec_q.ncyc),
        .busy(busy), .cnt(cnt), .last(last)
    );

    assign accept = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '{kind: K_BAD, ncyc: 2'd1, nbytes: 2'd0};
            b1_q  <= '0;
            b2_q  <= '0;
            ptr_q <= '0;
        end else begin
            if (accept) begin
                dec_q <= dec_in;
                b1_q  <= operand1;
                b2_q  <= operand2;
            end
            if (busy && cnt == '0) ptr_q <= iram_rdata;
        end
    end

    // pointer value is on the read port in the first busy cycle only
    assign ptr_now = (cnt == '0) ? iram_rdata : ptr_q;

    always_comb begin
        iram_addr  = '0;
        iram_we    = 1'b0;
        iram_wdata = '0;
        code_addr  = '0;
        code_re    = 1'b0;
        xd_addr    = '0;
        xd_re      = 1'b0;
        xd_we      = 1'b0;
        xd_wdata   = '0;
        acc_we     = 1'b0;
        acc_d      = '0;
        dph_we     = 1'b0;
        dpl_we     = 1'b0;
        dp_d       = '0;
        if (accept) iram_addr = ptr_reg_addr(bank_sel, opcode[0]);
        if (busy) begin
            unique case (dec_q.kind)
                K_DIR_IMM: if (last) begin
                    iram_we = 1'b1; iram_addr = b1_q; iram_wdata = b2_q;
                end
                K_IND_ACC: begin
                    iram_we = 1'b1; iram_addr = ptr_now; iram_wdata = acc;
                end
                K_IND_DIR: begin
                    if (cnt == '0) iram_addr = b1_q;
                    if (last) begin
                        iram_we = 1'b1; iram_addr = ptr_q; iram_wdata = iram_rdata;
                    end
                end
                K_IND_IMM: if (last) begin
                    iram_we = 1'b1; iram_addr = ptr_q; iram_wdata = b1_q;
                end
                K_LD_DPTR: begin
                    if (cnt == 2'd1) begin dph_we = 1'b1; dp_d = b1_q; end
                    if (cnt == 2'd2) begin dpl_we = 1'b1; dp_d = b2_q; end
                end
                K_CODE_DP, K_CODE_PC: begin
                    if (cnt == 2'd1) begin
                        code_re   = 1'b1;
                        code_addr = ((dec_q.kind == K_CODE_DP) ? dptr : pc + 16'd1)
                                    + addr_t'(acc);
                    end
                    if (last) begin acc_we = 1'b1; acc_d = code_rdata; end
                end
                K_XRD_RI, K_XRD_DP: begin
                    if (cnt == '0) begin
                        xd_re   = 1'b1;
                        xd_addr = (dec_q.kind == K_XRD_DP) ? dptr : {8'h00, ptr_now};
                    end
                    if (last) begin acc_we = 1'b1; acc_d = xd_rdata; end
                end
                K_XWR_RI, K_XWR_DP: if (last) begin
                    xd_we    = 1'b1;
                    xd_addr  = (dec_q.kind == K_XWR_DP) ? dptr : {8'h00, ptr_q};
                    xd_wdata = acc;
                end
                default: ;
            endcase
        end
    end

    assign done    = last;
    assign illegal = last && (dec_q.kind == K_BAD);
    assign pc_adv  = last && (dec_q.kind != K_BAD);

    dmu_arch_regs u_regs (
        .clk(clk), .rst(rst),
        .acc_we(acc_we), .acc_d(acc_d),
        .dph_we(dph_we), .dpl_we(dpl_we), .dp_d(dp_d),
        .pc_adv(pc_adv), .pc_step(dec_q.nbytes),
        .acc(acc), .dptr(dptr), .pc(pc)
    );

    // R2
    done_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);
    // R10
    illegal_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> done);
    // R10
    illegal_hold_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |=> ($stable(acc) && $stable(dptr) && $stable(pc)));
    // R11
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({iram_we, code_re, xd_re, xd_we}) <= 1);
    // R11
    strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (iram_we || code_re || xd_re || xd_we) |-> busy);
    // R11
    write_last_chk: assert property (@(posedge clk) disable iff (rst)
        (iram_we || xd_we) |-> done);
    // R6
    dph_first_chk: assert property (@(posedge clk) disable iff (rst)
        (done && dec_q.kind == K_LD_DPTR) |-> (dptr[15:8] == b1_q));
endmodule

// File: tb/dmove_unit_tb.sv
module dmove_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [7:0] opcode = '0, operand1 = '0, operand2 = '0;
    logic [1:0] bank_sel = '0;
    logic [7:0] iram_addr, iram_wdata, iram_rdata, code_rdata, xd_wdata, xd_rdata, acc;
    logic iram_we, code_re, xd_re, xd_we, busy, done, illegal;
    logic [15:0] code_addr, xd_addr, dptr, pc;

    int n_chk = 0, n_fail = 0;
    logic [7:0] iram_m [256];
    int iram_wr_n, xd_wr_n, strobe_viol;
    logic [15:0] xd_last_addr;
    logic [7:0] xd_last_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmove_unit u_dut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode),
        .operand1(operand1), .operand2(operand2), .bank_sel(bank_sel),
        .iram_addr(iram_addr), .iram_we(iram_we), .iram_wdata(iram_wdata),
        .iram_rdata(iram_rdata), .code_addr(code_addr), .code_re(code_re),
        .code_rdata(code_rdata), .xd_addr(xd_addr), .xd_re(xd_re), .xd_we(xd_we),
        .xd_wdata(xd_wdata), .xd_rdata(xd_rdata), .acc(acc), .dptr(dptr),
        .pc(pc), .busy(busy), .done(done), .illegal(illegal)
    );

    function automatic logic [7:0] code_fn(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction
    function automatic logic [7:0] xd_fn(input logic [15:0] a);
        return a[7:0] + a[15:8] + 8'h3C;
    endfunction

    always @(posedge clk) begin
        if (iram_we) begin
            iram_m[iram_addr] <= iram_wdata;
            iram_wr_n <= iram_wr_n + 1;
        end
        iram_rdata <= iram_m[iram_addr];
        code_rdata <= code_fn(code_addr);
        xd_rdata   <= xd_fn(xd_addr);
        if (xd_we) begin
            xd_wr_n <= xd_wr_n + 1;
            xd_last_addr <= xd_addr;
            xd_last_data <= xd_wdata;
        end
    end

    always @(negedge clk) begin
        if (!rst && (($countones({iram_we, code_re, xd_re, xd_we}) > 1) ||
            ((iram_we || code_re || xd_re || xd_we) && !busy)))
            strobe_viol = strobe_viol + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    int cyc_seen;
    bit ill_seen;
    logic [15:0] dptr_at_done;

    task automatic exec(input logic [7:0] op, b1, b2);
        @(negedge clk);
        iram_wr_n = 0; xd_wr_n = 0;
        opcode = op; operand1 = b1; operand2 = b2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc_seen = 0; ill_seen = 0;
        for (int k = 0; k < 8; k++) begin
            if (busy) cyc_seen++;
            if (done) begin
                ill_seen = illegal;
                dptr_at_done = dptr;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    // run an instruction and check its cycle count and pc advance (R2)
    task automatic run(input logic [7:0] op, b1, b2, input int ncyc, input int len);
        logic [15:0] pc0;
        pc0 = pc;
        exec(op, b1, b2);
        chk(cyc_seen == ncyc, "R2 busy cycles", cyc_seen, ncyc);
        chk(pc == pc0 + 16'(len), "R2 pc advance", pc, pc0 + 16'(len));
    endtask

    task automatic set_acc(input logic [7:0] v);
        run(8'h90, 8'h00, v - 8'h3C, 3, 3);
        run(8'hE0, 8'h00, 8'h00, 2, 1);
        chk(acc == v, "R8 movx dptr read", acc, v);
    endtask

    task automatic t_reset();
        chk(acc == 8'h00 && dptr == 16'h0 && pc == 16'h0, "R1 regs", {acc, dptr}, 0);
        chk(!busy && !done, "R1 idle", {busy, done}, 0);
    endtask

    task automatic t_dir_imm();
        run(8'h75, 8'h40, 8'h5A, 3, 3);
        chk(iram_m[8'h40] == 8'h5A, "R3 direct store", iram_m[8'h40], 8'h5A);
        chk(iram_wr_n == 1, "R11 single write", iram_wr_n, 1);
    endtask

    task automatic t_ld_dptr();
        logic [7:0] old_lo;
        old_lo = dptr[7:0];
        run(8'h90, 8'h12, 8'h34, 3, 3);
        chk(dptr == 16'h1234, "R6 dptr value", dptr, 16'h1234);
        chk(dptr_at_done == {8'h12, old_lo}, "R6 high byte first", dptr_at_done, {8'h12, old_lo});
    endtask

    task automatic t_ind_acc();
        set_acc(8'h77);
        @(negedge clk);
        bank_sel = 2'd0; iram_m[8'h01] = 8'h30;
        run(8'hF7, 8'h00, 8'h00, 1, 1);
        chk(iram_m[8'h30] == 8'h77, "R4 bank0 R1 store", iram_m[8'h30], 8'h77);
        @(negedge clk);
        bank_sel = 2'd2; iram_m[8'h10] = 8'h50;
        run(8'hF6, 8'h00, 8'h00, 1, 1);
        chk(iram_m[8'h50] == 8'h77, "R4 bank2 R0 store", iram_m[8'h50], 8'h77);
    endtask

    task automatic t_ind_dir_imm();
        @(negedge clk);
        bank_sel = 2'd1; iram_m[8'h08] = 8'h60; iram_m[8'h45] = 8'hC3;
        run(8'hA6, 8'h45, 8'h00, 2, 2);
        chk(iram_m[8'h60] == 8'hC3, "R5 direct to indirect", iram_m[8'h60], 8'hC3);
        @(negedge clk);
        bank_sel = 2'd3; iram_m[8'h19] = 8'h70;
        run(8'h77, 8'h99, 8'h00, 2, 2);
        chk(iram_m[8'h70] == 8'h99, "R5 immediate to indirect", iram_m[8'h70], 8'h99);
    endtask

    task automatic t_movc();
        logic [7:0] e;
        logic [15:0] p;
        set_acc(8'h20);
        run(8'h90, 8'hFF, 8'hF0, 3, 3);
        run(8'h93, 8'h00, 8'h00, 3, 1);
        e = code_fn(16'h0010);
        chk(acc == e, "R7 movc dptr wrap", acc, e);
        p = pc;
        e = code_fn(p + 16'd1 + {8'h00, acc});
        run(8'h83, 8'h00, 8'h00, 3, 1);
        chk(acc == e, "R7 movc pc relative", acc, e);
    endtask

    task automatic t_movx();
        logic [7:0] e, a0;
        @(negedge clk);
        bank_sel = 2'd0; iram_m[8'h00] = 8'h9C;
        run(8'hE2, 8'h00, 8'h00, 2, 1);
        e = xd_fn(16'h009C);
        chk(acc == e, "R8 movx Ri read", acc, e);
        a0 = acc;
        @(negedge clk);
        bank_sel = 2'd1; iram_m[8'h09] = 8'h44;
        run(8'hF3, 8'h00, 8'h00, 2, 1);
        chk(xd_wr_n == 1 && xd_last_addr == 16'h0044, "R9 movx Ri write addr", xd_last_addr, 16'h0044);
        chk(xd_last_data == a0, "R9 movx Ri write data", xd_last_data, a0);
        run(8'h90, 8'hBE, 8'hEF, 3, 3);
        run(8'hF0, 8'h00, 8'h00, 2, 1);
        chk(xd_last_addr == 16'hBEEF && xd_last_data == a0, "R9 movx dptr write", xd_last_addr, 16'hBEEF);
    endtask

    task automatic t_illegal(input logic [7:0] op);
        logic [7:0] a0;
        logic [15:0] d0, p0;
        a0 = acc; d0 = dptr; p0 = pc;
        exec(op, 8'h40, 8'hEE);
        chk(cyc_seen == 1, "R10 one cycle", cyc_seen, 1);
        chk(ill_seen, "R10 flag", ill_seen, 1);
        chk(acc == a0 && dptr == d0 && pc == p0, "R10 state held", pc, p0);
        chk(iram_wr_n == 0 && xd_wr_n == 0, "R10 no writes", iram_wr_n + xd_wr_n, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) iram_m[i] = 8'h00;
        iram_wr_n = 0; xd_wr_n = 0; strobe_viol = 0;
        xd_last_addr = '0; xd_last_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ld_dptr();
        t_dir_imm();
        t_ind_acc();
        t_ind_dir_imm();
        t_movc();
        t_movx();
        t_illegal(8'h00);
        t_illegal(8'hA5);
        chk(strobe_viol == 0, "R11 strobe rules", strobe_viol, 0);
        finish_run();
    end
endmodule